// File: doc/BRIEF.md
# SAR Conversion Sequencer with Pulse-Coded Power Modes

This block is the digital side of a 12-bit successive-approximation converter. All logic runs on one system clock. The serial clock and the conversion-start line are sampled as levels on that clock, and each is edge-detected against its value from the previous cycle. A conversion starts when conversion-start rises while the serial clock is high. From then on, each rising serial-clock edge settles one bit of the approximation register against the external comparator decision. The register is driven out as the DAC code. When all bits are settled, the result leaves the block serially, most significant bit first, one bit per rising serial-clock edge.

The same two pins carry a power command. Conversion-start pulses given while the serial clock stays low are counted. Two pulses drop the block into a light power-down state, and four pulses drop it into a deep one. Any sampled high level of the serial clock wakes the block and clears the count. A single counted pulse is treated as a deferred conversion request, and it starts a conversion when the serial clock next goes high.

The analog DAC, comparator and sampling switch lie outside the block. The DAC appears as the `dac_code` output and the comparator as the `cmp_ge` input.

Top module: `sar_adc_ctrl`

## Requirements
- R1: When `pwr_state` is 0 and `busy` is 0, a rising edge of `conv` sampled while `sclk` is high starts a conversion, and `busy` reads 1 from the next cycle.
- R2: On start, `dac_code` becomes 0x800, with only the top trial bit set. On each later rising `sclk` edge the current trial bit is kept if `cmp_ge` is 1 and cleared otherwise, and the next lower bit is set as the new trial. After 12 such edges `dac_code` holds the result.
- R3: The cycle after the 12th decision, `sdo_valid` goes to 1 and `sdo` presents the MSB of the result. Each later rising `sclk` edge presents the next lower bit. The rising edge after the LSB has been presented ends the transfer and clears `busy`. Whenever `sdo_valid` is 0, `sdo` is 0.
- R4: With `sclk` held low and the block active and idle, two rising `conv` edges set `pwr_state` to 1 (nap) from the cycle after the second edge.
- R5: With `sclk` held low, the fourth counted rising `conv` edge sets `pwr_state` to 2 (sleep). Further `conv` edges leave it at 2 while `sclk` stays low.
- R6: In nap or sleep, a sampled high `sclk` level returns `pwr_state` to 0 on the next cycle. A `conv` edge in that same cycle starts no conversion.
- R7: A `conv` edge while `busy` is 1 neither starts a conversion nor adds to the pulse count.
- R8: The pulse count clears whenever `sclk` is high. A count of exactly one starts a conversion on the next high `sclk`.
- R9: While `pwr_state` is 1 or 2, `busy` stays 0.
- R10: Synchronous active-high `rst` clears `busy`, `dac_code`, `sdo`, `sdo_valid`, `pwr_state` and the pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock level, sampled on `clk` |
| conv | input | 1 | Conversion-start level, sampled on `clk` |
| cmp_ge | input | 1 | Comparator: analog input at or above the DAC level |
| dac_code | output | 12 | Code driven to the DAC |
| sdo | output | 1 | Serial result bit |
| sdo_valid | output | 1 | High while a result bit is presented |
| busy | output | 1 | Conversion or transfer in progress |
| pwr_state | output | 2 | 0 active, 1 nap, 2 sleep |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is wake-up and conversion start: while the block is napping, the bench raises `sclk` and `conv` on the same edge, and it expects a return to active with `busy` still 0. The second pair is the end of the serial transfer and a new start request: the bench raises `conv` on the same edge as the final `sclk` rise, and it expects the transfer to close with no new conversion, because `busy` was still set in that cycle. In both cases a behavioural model predicts every output on every cycle, and directed checks confirm the final state.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_SLEEP  = 2'd2
  } pwr_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CONV  = 2'd1,
    PH_SHIFT = 2'd2
  } phase_e;

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] lvl_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (rst) lvl_q[i] <= 1'b0;
      else     lvl_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end

endmodule

// File: rtl/sar_pwr_seq.sv
module sar_pwr_seq
  import sar_pkg::*;
#(
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_lvl,
  input  logic conv_rise,
  input  logic busy,
  output pwr_e pwr_state,
  output logic start_req
);

  localparam int CW = $clog2(SLEEP_PULSES + 1);
  localparam logic [CW-1:0] NAP_C = CW'(NAP_PULSES);
  localparam logic [CW-1:0] SLP_C = CW'(SLEEP_PULSES);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  pwr_e          pwr_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          wake_evt;
  logic          count_evt;

  assign cnt_inc   = cnt_q + ONE_C;
  assign wake_evt  = (pwr_q != PWR_ACTIVE) && sclk_lvl;
  assign count_evt = !sclk_lvl && conv_rise && !busy && (cnt_q != SLP_C);
  assign start_req = (pwr_q == PWR_ACTIVE) && !busy && sclk_lvl &&
                     (conv_rise || (cnt_q == ONE_C));
  assign pwr_state = pwr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q <= PWR_ACTIVE;
      cnt_q <= '0;
    end else if (sclk_lvl) begin
      cnt_q <= '0;
      if (wake_evt) pwr_q <= PWR_ACTIVE;
    end else if (count_evt) begin
      cnt_q <= cnt_inc;
      if (cnt_inc == SLP_C)
        pwr_q <= PWR_SLEEP;
      else if ((cnt_inc == NAP_C) && (pwr_q == PWR_ACTIVE))
        pwr_q <= PWR_NAP;
    end
  end

  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (rst)
    sclk_lvl |=> (cnt_q == '0));

  p_wake_r6: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> (pwr_q == PWR_ACTIVE));

  p_sleep_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ((pwr_q == PWR_SLEEP) && !sclk_lvl) |=> (pwr_q == PWR_SLEEP));

  p_busy_ignores_conv_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_rise && !sclk_lvl) |=> $stable(cnt_q));

  p_quiet_in_powerdown_r9: assert property (@(posedge clk) disable iff (rst)
    (pwr_q != PWR_ACTIVE) |-> !busy);

endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         sclk_rise,
  input  logic         cmp_ge,
  output logic [W-1:0] dac_code,
  output logic         sdo,
  output logic         sdo_valid,
  output logic         busy
);

  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] TOP = IW'(W - 1);

  function automatic logic [W-1:0] bit_mask(input logic [IW-1:0] i);
    logic [W-1:0] m;
    m = '0;
    m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [W-1:0] low_mask(input logic [IW-1:0] i);
    return bit_mask(i) - W'(1);
  endfunction

  function automatic logic [W-1:0] decide(input logic [W-1:0] code,
                                          input logic [IW-1:0] i,
                                          input logic keep);
    logic [W-1:0] r;
    r = keep ? code : (code & ~bit_mask(i));
    if (i != '0) r = r | bit_mask(i - IW'(1));
    return r;
  endfunction

  phase_e        phase_q;
  logic [W-1:0]  sar_q;
  logic [W-1:0]  sh_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] shcnt_q;

  logic          trial_step;
  logic          last_trial;
  logic          shift_step;
  logic          last_shift;
  logic          begin_conv;
  logic [W-1:0]  sar_next;

  assign begin_conv = start && (phase_q == PH_IDLE);
  assign trial_step = (phase_q == PH_CONV) && sclk_rise;
  assign last_trial = trial_step && (idx_q == '0);
  assign shift_step = (phase_q == PH_SHIFT) && sclk_rise;
  assign last_shift = shift_step && (shcnt_q == TOP);
  assign sar_next   = decide(sar_q, idx_q, cmp_ge);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      sar_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      shcnt_q <= '0;
    end else if (begin_conv) begin
      phase_q <= PH_CONV;
      sar_q   <= bit_mask(TOP);
      idx_q   <= TOP;
    end else if (trial_step) begin
      sar_q <= sar_next;
      if (last_trial) begin
        phase_q <= PH_SHIFT;
        sh_q    <= sar_next;
        shcnt_q <= '0;
      end else begin
        idx_q <= idx_q - IW'(1);
      end
    end else if (shift_step) begin
      if (last_shift) begin
        phase_q <= PH_IDLE;
      end else begin
        sh_q    <= sh_q << 1;
        shcnt_q <= shcnt_q + IW'(1);
      end
    end
  end

  assign dac_code  = sar_q;
  assign sdo_valid = (phase_q == PH_SHIFT);
  assign sdo       = sdo_valid & sh_q[W-1];
  assign busy      = (phase_q != PH_IDLE);

  p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_trial_clean_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CONV) |-> ((sar_q & low_mask(idx_q)) == '0));

  p_valid_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    last_trial |=> (sdo_valid && (sdo == $past(sar_next[W-1]))));

  p_sdo_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (sdo_valid && !sclk_rise) |=> $stable(sdo));

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int W            = 12,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk,
  input  logic         conv,
  input  logic         cmp_ge,
  output logic [W-1:0] dac_code,
  output logic         sdo,
  output logic         sdo_valid,
  output logic         busy,
  output logic [1:0]   pwr_state
);

  logic [1:0] rise;
  logic       sclk_rise;
  logic       conv_rise;
  logic       start_req;
  pwr_e       pwr_w;

  sar_edge_sync #(.N(2)) u_edges (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({conv, sclk}),
    .rise (rise)
  );

  assign sclk_rise = rise[0];
  assign conv_rise = rise[1];

  sar_pwr_seq #(
    .NAP_PULSES   (NAP_PULSES),
    .SLEEP_PULSES (SLEEP_PULSES)
  ) u_pwr (
    .clk       (clk),
    .rst       (rst),
    .sclk_lvl  (sclk),
    .conv_rise (conv_rise),
    .busy      (busy),
    .pwr_state (pwr_w),
    .start_req (start_req)
  );

  sar_engine #(.W(W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .start     (start_req),
    .sclk_rise (sclk_rise),
    .cmp_ge    (cmp_ge),
    .dac_code  (dac_code),
    .sdo       (sdo),
    .sdo_valid (sdo_valid),
    .busy      (busy)
  );

  assign pwr_state = pwr_w;

endmodule

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        conv = 1'b0;
  logic        cmp_ge;
  logic [11:0] dac_code;
  logic        sdo;
  logic        sdo_valid;
  logic        busy;
  logic [1:0]  pwr_state;
  int          vin = 0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign cmp_ge = (vin >= int'(dac_code));

  sar_adc_ctrl u_sar_adc_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .conv      (conv),
    .cmp_ge    (cmp_ge),
    .dac_code  (dac_code),
    .sdo       (sdo),
    .sdo_valid (sdo_valid),
    .busy      (busy),
    .pwr_state (pwr_state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 deciding, 2 shifting
  int m_phase, m_idx, m_nsh, m_pwr, m_cnt, m_dac;
  bit m_sq, m_cq, m_cr, m_sr, m_st;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_idx = 0; m_nsh = 0; m_pwr = 0; m_cnt = 0; m_dac = 0;
      m_sq = 0; m_cq = 0;
    end else begin
      m_cr = conv && !m_cq;
      m_sr = sclk && !m_sq;
      m_st = 0;
      if (m_pwr != 0) begin
        if (sclk) begin m_pwr = 0; m_cnt = 0; end
        else if (m_cr && m_cnt < 4) begin
          m_cnt++;
          if (m_cnt == 4) m_pwr = 2;
        end
      end else if (m_phase == 0) begin
        if (sclk) begin m_st = m_cr || (m_cnt == 1); m_cnt = 0; end
        else if (m_cr) begin
          m_cnt++;
          if (m_cnt == 2) m_pwr = 1;
        end
      end
      if (m_st) begin
        m_phase = 1; m_idx = 11; m_dac = 'h800;
      end else if (m_phase == 1 && m_sr) begin
        if (m_idx == 0) begin m_phase = 2; m_nsh = 0; m_dac = vin; end
        else begin
          m_idx--;
          m_dac = (vin & ~((1 << (m_idx + 1)) - 1)) | (1 << m_idx);
        end
      end else if (m_phase == 2 && m_sr) begin
        if (m_nsh == 11) m_phase = 0;
        else m_nsh++;
      end
      m_cq = conv;
      m_sq = sclk;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      int esdo;
      esdo = (m_phase == 2) ? ((vin >> (11 - m_nsh)) & 1) : 0;
      chk(busy == (m_phase != 0), "R1 busy", busy, m_phase != 0);
      chk(int'(dac_code) == m_dac, "R2 dac_code", dac_code, m_dac);
      chk(sdo_valid == (m_phase == 2), "R3 sdo_valid", sdo_valid, m_phase == 2);
      chk(int'(sdo) == esdo, "R3 sdo", sdo, esdo);
      chk(int'(pwr_state) == m_pwr, "R4 R5 R6 pwr_state", pwr_state, m_pwr);
    end
  end

  task automatic sclk_pulse_c(input bit c);
    @(negedge clk) sclk = 1'b1;
    @(negedge clk) conv = c;
    @(negedge clk) begin sclk = 1'b0; conv = 1'b0; end
    @(negedge clk);
  endtask

  task automatic sclk_pulse();
    sclk_pulse_c(1'b0);
  endtask

  task automatic both_pulse();
    @(negedge clk) begin sclk = 1'b1; conv = 1'b1; end
    @(negedge clk);
    @(negedge clk) begin sclk = 1'b0; conv = 1'b0; end
    @(negedge clk);
  endtask

  task automatic conv_low_pulse();
    @(negedge clk) conv = 1'b1;
    @(negedge clk);
    @(negedge clk) conv = 1'b0;
    @(negedge clk);
  endtask

  // mode 0: direct start, 1: deferred single pulse; noise: conv edges while busy; tail: conv on last sclk rise
  task automatic convert(input int v, input int mode, input bit noise, input bit tail);
    logic [11:0] got;
    vin = v;
    if (mode == 0) both_pulse();
    else begin conv_low_pulse(); sclk_pulse(); end
    chk(busy == 1'b1, "R1 start", busy, 1);
    for (int i = 0; i < 12; i++) begin
      if (noise && i == 5) begin conv_low_pulse(); sclk_pulse_c(1'b1); end
      else sclk_pulse();
    end
    for (int k = 0; k < 12; k++) begin
      got[11-k] = sdo;
      chk(sdo_valid == 1'b1, "R3 valid during transfer", sdo_valid, 1);
      if (tail && k == 11) both_pulse();
      else sclk_pulse();
    end
    chk(got == 12'(v), "R2 R3 serial result", got, v);
    chk(sdo_valid == 1'b0 && sdo == 1'b0, "R3 idle output", {sdo_valid, sdo}, 0);
    chk(busy == 1'b0, "R7 R3 done", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 0 && dac_code == 0 && pwr_state == 0 && sdo_valid == 0,
        "R10 reset state", {busy, pwr_state, sdo_valid}, 0);

    convert('hA5C, 0, 0, 0);
    convert(0, 0, 0, 0);
    convert('hFFF, 1, 0, 0);
    convert('h001, 0, 1, 0);
    sclk_pulse();
    chk(busy == 0 && pwr_state == 0, "R7 busy-time pulse not counted", busy, 0);
    convert('h800, 0, 0, 1);
    chk(busy == 0, "R7 edge at transfer end ignored", busy, 0);

    // R8: the single pulse before a deferred start must not linger
    convert('h7FF, 1, 0, 0);
    conv_low_pulse();
    chk(pwr_state == 0, "R8 count cleared by high sclk", pwr_state, 0);
    sclk_pulse();
    chk(busy == 1, "R8 single pulse deferred start", busy, 1);
    for (int i = 0; i < 24; i++) sclk_pulse();
    chk(busy == 0, "R8 deferred conversion finished", busy, 0);

    // R4, R9, R6: nap, ignore, wake with coincident start request
    conv_low_pulse();
    conv_low_pulse();
    chk(pwr_state == 1, "R4 nap entered", pwr_state, 1);
    conv_low_pulse();
    chk(pwr_state == 1 && busy == 0, "R9 nap holds, no conversion", pwr_state, 1);
    both_pulse();
    chk(pwr_state == 0, "R6 woken from nap", pwr_state, 0);
    chk(busy == 0, "R6 coincident start dropped", busy, 0);

    // R5: sleep and its wake
    for (int i = 0; i < 4; i++) conv_low_pulse();
    chk(pwr_state == 2, "R5 sleep entered", pwr_state, 2);
    conv_low_pulse();
    chk(pwr_state == 2 && busy == 0, "R5 R9 sleep sticky", pwr_state, 2);
    sclk_pulse();
    chk(pwr_state == 0 && busy == 0, "R6 woken from sleep", pwr_state, 0);
    convert('h3C3, 0, 0, 0);

    // R10: reset mid-conversion and reset of the pulse count
    vin = 'h5A5;
    both_pulse();
    repeat (3) sclk_pulse();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(busy == 0 && dac_code == 0 && sdo_valid == 0, "R10 reset mid-conversion",
        dac_code, 0);
    conv_low_pulse();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    sclk_pulse();
    chk(busy == 0, "R10 pulse count cleared", busy, 0);
    conv_low_pulse();
    chk(pwr_state == 0, "R10 R4 count restarts from zero", pwr_state, 0);
    sclk_pulse();
    for (int i = 0; i < 24; i++) sclk_pulse();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule